// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point signal-processing engine. Two 16-bit operand registers (X and Y) hold two's-complement fractions. Each cycle a signed multiplier forms their product. The product is kept to 24 bits in a product register. A 24-bit accumulator is updated by an ALU. The ALU's second operand is either the product register or a 16-bit data word placed in the upper 16 bits of the 24-bit path.

A four-way shifter sits between that operand and the ALU. A scaling control forces a 3-bit arithmetic right shift whenever the product is the operand. An optional saturation control clamps results that leave the 24-bit signed range to the nearest limit; without it, such results wrap. Every ALU operation refreshes four flags: negative, overflow, zero and carry. The accumulator's upper 16 bits are presented as the 16-bit read value.

Instruction decode, memories and sequencing are outside the block. The surrounding controller drives the operation code, the operand select, the shift code and the two mode bits on each cycle.

Top module: `frac_mac_dp`

## Requirements
- R1: When `x_we`/`y_we` is high at a clock edge, X/Y take `x_in`/`y_in`. At the following edge `p_out` takes bits 30 down to 7 of the signed 32-bit product X*Y. This is the top 24 bits of the fractional product.
- R2: With X = 0x8000 and Y = 0x8000, the product register holds 0x800000 (-1), never +1.
- R3: The ALU operand is `p_out` when `src_p`=1. When `src_p`=0 it is `{d_in, 8'h00}`. Operation MAC always uses `p_out`, regardless of `src_p`.
- R4: Shift code `sh` selects the operand shift before the ALU:
  - 0: none.
  - 1: arithmetic right by 1.
  - 2: arithmetic right by 3.
  - 3: left by 1, zero fill, kept as a 25-bit value so that no bit is lost before the overflow test.
- R5: When `scale_en`=1 and the operand is the product, the shift is arithmetic right by 3 whatever `sh` says. With a data-word operand, `scale_en` has no effect.
- R6: `op` encoding:
  - 0: NOP.
  - 1: LOAD (acc = operand).
  - 2: ADD (acc + operand).
  - 3: SUB (acc - operand).
  - 4: MAC (acc + product).
  - 5 to 7: NOP.

  A NOP leaves the accumulator and all flags unchanged.
- R7: LOAD of a data word with no shift gives acc = `{d_in, 8'h00}`. `acc_hi` always shows acc[23:16+...] i.e. the upper 16 bits of the accumulator.
- R8: The overflow flag `flag_v` is set when the exact result lies outside [-2^23, 2^23-1]. With `sat_en`=0 the accumulator then takes the low 24 bits (wraparound).
- R9: With `sat_en`=1 and overflow, the accumulator takes 0x7FFFFF for a positive exact result and 0x800000 for a negative one. `flag_v` is still set.
- R10: After each operation:
  - `flag_n` is acc bit 23 and `flag_z` is acc==0.
  - `flag_c` is the unsigned carry out of acc + operand[23:0] for ADD/MAC.
  - `flag_c` is the unsigned borrow (acc < operand[23:0]) for SUB.
  - `flag_c` is 0 for LOAD.
- R11: While `rst_n` is low, X, Y, the product register, the accumulator and all four flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_we | input | 1 | Load X from x_in |
| x_in | input | 16 | Multiplier X operand |
| y_we | input | 1 | Load Y from y_in |
| y_in | input | 16 | Multiplier Y operand |
| op | input | 3 | ALU operation code |
| src_p | input | 1 | Operand source: 1 product, 0 data word |
| d_in | input | 16 | Data word for the ALU operand |
| sh | input | 2 | Operand shift code |
| scale_en | input | 1 | Force 3-bit right shift on product operand |
| sat_en | input | 1 | Clamp instead of wrap on overflow |
| p_out | output | 24 | Product register |
| acc_out | output | 24 | Accumulator |
| acc_hi | output | 16 | Upper 16 bits of the accumulator |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
The assertions check the following on every cycle:
- The -1 times -1 product result.
- That a NOP holds the accumulator and flags.
- The placement of a 16-bit word on an unshifted load.
- That a saturating operation never leaves an overflowed value other than a limit.
- That the zero and negative flags agree with the stored accumulator.

The bench's directed scenarios are needed for the rest:
- Exact product truncation for chosen operand pairs.
- Each shift code and the scaling override.
- Wraparound values.
- The sense of carry versus borrow.
- The rule that the multiply-accumulate operation ignores the source select.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LOAD = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_MAC  = 3'd4
   } fmac_op_e;

   typedef enum logic [1:0] {
      SH_NONE = 2'd0,
      SH_R1   = 2'd1,
      SH_R3   = 2'd2,
      SH_L1   = 2'd3
   } fmac_sh_e;

   typedef enum logic [1:0] {
      K_LOAD = 2'd0,
      K_ADD  = 2'd1,
      K_SUB  = 2'd2
   } fmac_kind_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } fmac_flags_t;

endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
   parameter int DW = 16,
   parameter int AW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          x_we,
   input  logic [DW-1:0] x_in,
   input  logic          y_we,
   input  logic [DW-1:0] y_in,
   output logic [DW-1:0] x_q,
   output logic [DW-1:0] y_q,
   output logic [AW-1:0] p_q
);
   localparam int PW = 2 * DW;

   logic signed [PW-1:0] raw;
   logic        [AW-1:0] p_d;

   always_comb raw = $signed(x_q) * $signed(y_q);

   // fractional alignment: drop the duplicate sign bit, keep AW bits below it
   assign p_d = raw[PW-2 -: AW];

   generate
      if (AW < PW - 1) begin : g_drop_low
         logic unused_low;
         assign unused_low = ^{raw[PW-1], raw[PW-AW-2:0]};
      end else begin : g_keep_all
         logic unused_top;
         assign unused_top = raw[PW-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         p_q <= '0;
      end else begin
         if (x_we) x_q <= x_in;
         if (y_we) y_q <= y_in;
         p_q <= p_d;
      end
   end
endmodule

// File: rtl/fmac_shift.sv
module fmac_shift
   import fmac_pkg::*;
#(
   parameter int AW       = 24,
   parameter int SCALE_SH = 3
) (
   input  logic [AW-1:0] opnd,
   input  logic [1:0]    sh,
   input  logic          force_scale,
   output logic [AW:0]   shifted
);
   logic signed [AW:0] ext;
   fmac_sh_e           eff;

   assign ext = $signed({opnd[AW-1], opnd});
   assign eff = force_scale ? SH_R3 : fmac_sh_e'(sh);

   always_comb begin
      case (eff)
         SH_R1:   shifted = ext >>> 1;
         SH_R3:   shifted = ext >>> SCALE_SH;
         SH_L1:   shifted = {opnd, 1'b0};
         default: shifted = ext;
      endcase
   end
endmodule

// File: rtl/fmac_alu.sv
module fmac_alu
   import fmac_pkg::*;
#(
   parameter int AW = 24
) (
   input  logic [AW-1:0] acc,
   input  logic [AW:0]   opnd,
   input  fmac_kind_e    kind,
   input  logic          sat_en,
   output logic [AW-1:0] res,
   output fmac_flags_t   flags
);
   localparam int          RW   = AW + 2;
   localparam logic [AW-1:0] MAXP = {1'b0, {(AW-1){1'b1}}};
   localparam logic [AW-1:0] MINN = {1'b1, {(AW-1){1'b0}}};

   logic signed [RW-1:0] a_x, b_x, exact;
   logic        [AW-1:0] b_lo, usum;
   logic                 ovf, cy;

   assign a_x  = $signed({{2{acc[AW-1]}}, acc});
   assign b_x  = $signed({opnd[AW], opnd});
   assign b_lo = opnd[AW-1:0];
   assign usum = acc + b_lo;

   always_comb begin
      case (kind)
         K_ADD:   begin exact = a_x + b_x; cy = (usum < acc); end
         K_SUB:   begin exact = a_x - b_x; cy = (acc < b_lo); end
         default: begin exact = b_x;       cy = 1'b0;         end
      endcase
   end

   // out of range when the bits above the 24-bit sign are not all copies of it
   assign ovf = !((&exact[RW-1:AW-1]) || !(|exact[RW-1:AW-1]));

   always_comb begin
      if (sat_en && ovf) res = exact[RW-1] ? MINN : MAXP;
      else               res = exact[AW-1:0];
   end

   assign flags.n = res[AW-1];
   assign flags.v = ovf;
   assign flags.z = (res == '0);
   assign flags.c = cy;
endmodule

// File: rtl/frac_mac_dp.sv
module frac_mac_dp
   import fmac_pkg::*;
#(
   parameter int DW       = 16,
   parameter int AW       = 24,
   parameter int SCALE_SH = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          x_we,
   input  logic [DW-1:0] x_in,
   input  logic          y_we,
   input  logic [DW-1:0] y_in,
   input  logic [2:0]    op,
   input  logic          src_p,
   input  logic [DW-1:0] d_in,
   input  logic [1:0]    sh,
   input  logic          scale_en,
   input  logic          sat_en,
   output logic [AW-1:0] p_out,
   output logic [AW-1:0] acc_out,
   output logic [DW-1:0] acc_hi,
   output logic          flag_n,
   output logic          flag_v,
   output logic          flag_z,
   output logic          flag_c
);
   localparam int PAD = AW - DW;

   generate
      if (DW < 2 || AW <= DW || AW > 2 * DW - 1) begin : g_bad_width
         $error("frac_mac_dp: need 2 <= DW < AW <= 2*DW-1");
      end
      if (SCALE_SH < 1 || SCALE_SH >= AW) begin : g_bad_scale
         $error("frac_mac_dp: SCALE_SH out of range");
      end
   endgenerate

   logic [DW-1:0] x_q, y_q;
   logic [AW-1:0] p_q, acc_q, opnd, alu_res;
   logic [AW:0]   shifted;
   fmac_flags_t   flg_q, alu_flg;
   fmac_op_e      opc;
   fmac_kind_e    kind;
   logic          active, use_p;

   fmac_mult #(.DW(DW), .AW(AW)) u_mult (
      .clk(clk), .rst_n(rst_n),
      .x_we(x_we), .x_in(x_in), .y_we(y_we), .y_in(y_in),
      .x_q(x_q), .y_q(y_q), .p_q(p_q)
   );

   assign opc   = fmac_op_e'(op);
   assign use_p = src_p || (opc == OP_MAC);
   assign opnd  = use_p ? p_q : {d_in, {PAD{1'b0}}};

   always_comb begin
      active = 1'b1;
      case (opc)
         OP_LOAD:        kind = K_LOAD;
         OP_ADD, OP_MAC: kind = K_ADD;
         OP_SUB:         kind = K_SUB;
         default: begin  kind = K_LOAD; active = 1'b0; end
      endcase
   end

   fmac_shift #(.AW(AW), .SCALE_SH(SCALE_SH)) u_shift (
      .opnd(opnd), .sh(sh), .force_scale(scale_en && use_p), .shifted(shifted)
   );

   fmac_alu #(.AW(AW)) u_alu (
      .acc(acc_q), .opnd(shifted), .kind(kind), .sat_en(sat_en),
      .res(alu_res), .flags(alu_flg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         flg_q <= '0;
      end else if (active) begin
         acc_q <= alu_res;
         flg_q <= alu_flg;
      end
   end

   assign p_out   = p_q;
   assign acc_out = acc_q;
   assign acc_hi  = acc_q[AW-1 -: DW];
   assign flag_n  = flg_q.n;
   assign flag_v  = flg_q.v;
   assign flag_z  = flg_q.z;
   assign flag_c  = flg_q.c;
endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
   parameter int DW = 16,
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    op,
   input logic          src_p,
   input logic [DW-1:0] d_in,
   input logic [1:0]    sh,
   input logic          sat_en,
   input logic [DW-1:0] x_q,
   input logic [DW-1:0] y_q,
   input logic [AW-1:0] p_out,
   input logic [AW-1:0] acc_out,
   input logic          flag_n,
   input logic          flag_v,
   input logic          flag_z,
   input logic          flag_c
);
   localparam logic [DW-1:0] NEG1_D = {1'b1, {(DW-1){1'b0}}};
   localparam logic [AW-1:0] NEG1_A = {1'b1, {(AW-1){1'b0}}};
   localparam logic [AW-1:0] POSMAX = {1'b0, {(AW-1){1'b1}}};

   logic is_active, is_nop;
   assign is_active = (op >= 3'd1) && (op <= 3'd4);
   assign is_nop    = !is_active;

   AST_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (x_q == NEG1_D && y_q == NEG1_D) |=> (p_out == NEG1_A)); // R2

   AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop |=> ($stable(acc_out) && $stable({flag_n, flag_v, flag_z, flag_c}))); // R6

   AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd1 && !src_p && sh == 2'd0) |=> (acc_out == {$past(d_in), {(AW-DW){1'b0}}})); // R7

   AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (is_active && sat_en) |=> (!flag_v || acc_out == POSMAX || acc_out == NEG1_A)); // R9

   AST_NZ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      is_active |=> ((flag_z == (acc_out == '0)) && (flag_n == acc_out[AW-1]))); // R10
endmodule

bind frac_mac_dp fmac_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .op(op), .src_p(src_p), .d_in(d_in), .sh(sh),
   .sat_en(sat_en), .x_q(x_q), .y_q(y_q), .p_out(p_out), .acc_out(acc_out),
   .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/frac_mac_dp_test.sv
`timescale 1ns/1ps
module frac_mac_dp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        x_we = 0, y_we = 0, src_p = 0, scale_en = 0, sat_en = 0;
   logic [15:0] x_in = 0, y_in = 0, d_in = 0;
   logic [2:0]  op = 0;
   logic [1:0]  sh = 0;
   logic [23:0] p_out, acc_out;
   logic [15:0] acc_hi;
   logic        flag_n, flag_v, flag_z, flag_c;
   int          errors = 0, checks = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   frac_mac_dp uut (
      .clk(clk), .rst_n(rst_n), .x_we(x_we), .x_in(x_in), .y_we(y_we), .y_in(y_in),
      .op(op), .src_p(src_p), .d_in(d_in), .sh(sh), .scale_en(scale_en), .sat_en(sat_en),
      .p_out(p_out), .acc_out(acc_out), .acc_hi(acc_hi),
      .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
   );

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // flags packed as {n,v,z,c}
   task automatic chk_f(input string tag, input logic [3:0] exp);
      chk(tag, {20'h0, flag_n, flag_v, flag_z, flag_c}, {20'h0, exp});
   endtask

   task automatic load_xy(input logic [15:0] x, input logic [15:0] y);
      x_in = x; y_in = y; x_we = 1; y_we = 1;
      @(posedge clk); @(negedge clk);
      x_we = 0; y_we = 0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_op(input logic [2:0] o, input logic sp, input logic [15:0] d,
                        input logic [1:0] s, input logic sc, input logic sat);
      op = o; src_p = sp; d_in = d; sh = s; scale_en = sc; sat_en = sat;
      @(posedge clk); @(negedge clk);
      op = 3'd0; src_p = 0; scale_en = 0; sat_en = 0; sh = 0;
   endtask

   task automatic t_reset;
      chk("R11 acc reset", acc_out, 24'h0);
      chk("R11 p reset", p_out, 24'h0);
      chk_f("R11 flags reset", 4'b0000);
   endtask

   task automatic t_multiply;
      load_xy(16'h4000, 16'h4000);
      chk("R1 0.5*0.5", p_out, 24'h200000);
      load_xy(16'h8000, 16'h4000);
      chk("R1 -1*0.5", p_out, 24'hC00000);
      load_xy(16'h8000, 16'h8000);
      chk("R2 -1*-1", p_out, 24'h800000);
   endtask

   task automatic t_load_word;
      do_op(3'd1, 0, 16'h1234, 2'd0, 0, 0);
      chk("R7 load word", acc_out, 24'h123400);
      chk("R7 acc_hi", {8'h0, acc_hi}, 24'h001234);
      chk_f("R10 load flags", 4'b0000);
   endtask

   task automatic t_mac;
      load_xy(16'h4000, 16'h4000);
      do_op(3'd4, 0, 16'h7777, 2'd0, 0, 0);
      chk("R3 MAC uses product", acc_out, 24'h323400);
      do_op(3'd1, 0, 16'h0000, 2'd0, 0, 0);
      chk_f("R10 zero flag", 4'b0010);
      do_op(3'd4, 0, 16'h0, 2'd0, 1, 0);
      chk("R5 scale forces >>>3", acc_out, 24'h040000);
      do_op(3'd3, 1, 16'h0, 2'd1, 0, 0);
      chk("R3 sub product >>>1", acc_out, 24'hF40000);
      chk_f("R10 borrow", 4'b1001);
   endtask

   task automatic t_shifts;
      do_op(3'd1, 0, 16'h0000, 2'd0, 0, 0);
      do_op(3'd2, 0, 16'h8000, 2'd1, 0, 0);
      chk("R4 >>>1 sign", acc_out, 24'hC00000);
      do_op(3'd1, 0, 16'h1000, 2'd2, 0, 0);
      chk("R4 >>>3", acc_out, 24'h020000);
      do_op(3'd1, 0, 16'h1000, 2'd3, 0, 0);
      chk("R4 <<1", acc_out, 24'h200000);
      do_op(3'd1, 0, 16'h1000, 2'd0, 1, 0);
      chk("R5 scale ignored for data", acc_out, 24'h100000);
   endtask

   task automatic t_overflow;
      do_op(3'd1, 0, 16'h7FFF, 2'd0, 0, 0);
      do_op(3'd2, 0, 16'h0100, 2'd0, 0, 0);
      chk("R8 wrap", acc_out, 24'h80FF00);
      chk_f("R8 wrap flags", 4'b1100);
      do_op(3'd1, 0, 16'h7FFF, 2'd0, 0, 0);
      do_op(3'd2, 0, 16'h0100, 2'd0, 0, 1);
      chk("R9 clamp positive", acc_out, 24'h7FFFFF);
      chk_f("R9 clamp flags", 4'b0100);
      do_op(3'd1, 0, 16'h8000, 2'd0, 0, 0);
      do_op(3'd3, 0, 16'h0100, 2'd0, 0, 1);
      chk("R9 clamp negative", acc_out, 24'h800000);
      chk_f("R9 neg clamp flags", 4'b1100);
      do_op(3'd1, 0, 16'h4000, 2'd3, 0, 0);
      chk("R8 left shift wrap", acc_out, 24'h800000);
      chk_f("R8 left shift ovf", 4'b1100);
      do_op(3'd1, 0, 16'h4000, 2'd3, 0, 1);
      chk("R9 left shift clamp", acc_out, 24'h7FFFFF);
   endtask

   task automatic t_carry;
      do_op(3'd1, 0, 16'hFFFF, 2'd0, 0, 0);
      do_op(3'd2, 0, 16'h0001, 2'd0, 0, 0);
      chk("R10 carry sum", acc_out, 24'h000000);
      chk_f("R10 carry flags", 4'b0011);
      do_op(3'd3, 0, 16'h0001, 2'd0, 0, 0);
      chk("R10 borrow sum", acc_out, 24'hFFFF00);
      chk_f("R10 borrow flags", 4'b1001);
   endtask

   task automatic t_nop;
      do_op(3'd0, 1, 16'hAAAA, 2'd3, 1, 1);
      chk("R6 NOP holds acc", acc_out, 24'hFFFF00);
      chk_f("R6 NOP holds flags", 4'b1001);
      do_op(3'd7, 0, 16'h5555, 2'd1, 0, 0);
      chk("R6 code 7 holds acc", acc_out, 24'hFFFF00);
      chk_f("R6 code 7 holds flags", 4'b1001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_multiply();
      t_load_word();
      t_mac();
      t_shifts();
      t_overflow();
      t_carry();
      t_nop();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule